// File: doc/BRIEF.md
# ATA PIO Host Cycle Timer

This block sits on the host side of a parallel ATA bus. It runs one register or data access at a time in any PIO mode from 0 to 6. A request carries a 3-bit register address, two chip selects, a direction, an access-width flag and the write data. The block then drives the address, the chip selects, the active-low read or write strobe and the data-bus output enable. It completes the access with a one-clock `done` pulse, and for reads it returns the captured data.

Each nanosecond minimum is turned into a whole number of clock cycles by a compile-time ceiling, taking `CLK_NS` as the period (10 ns by default). The access is built from three phases:

- a setup phase with address valid and strobe inactive;
- a strobe phase, which a slow device may stretch with IORDY;
- a recovery phase that covers the address and data hold times and the mode's recovery minimum.

The recovery phase is also extended until the whole access reaches the mode's minimum cycle time. In modes 5 and 6 IORDY is not used. In slower modes a stretch longer than 1250 ns is cut short and reported as a timeout.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset `busy`, `done`, `timeout` and `bus_oe` are 0. `ata_rd_n` and `ata_wr_n` are 1, and `ata_cs_n` is 2'b11.
- R2: A request is accepted on a clock edge where `req_valid` is high and the block is idle. From the next cycle `ata_addr` equals the request address and `ata_cs_n` equals the inverted request selects, both held until `done`. The strobe first goes low after S cycles of setup, where S = ceil(t_setup/CLK_NS) and t_setup is 70, 50, 30, 30, 25, 15, 10 ns for modes 0..6.
- R3: When `req_wide` is 1 and IORDY is high, the strobe is low for exactly ceil(t_width/CLK_NS) cycles. t_width is 165, 125, 100, 80, 70, 65, 55 ns for modes 0..6.
- R4: When `req_wide` is 0, the strobe width uses 290 ns in modes 0, 1 and 2, and the same value as R3 in modes 3 to 6.
- R5: After the strobe rises, the block stays busy for H cycles and then pulses `done` in the cycle busy drops. H is the larger of two values. The first is the largest of the ceilings of the address hold (20, 15, 10, 10, 10, 10, 10 ns), the data hold (30, 20, 15, 10, 10, 5, 5 ns) and the recovery minimum (0, 0, 0, 70, 25, 25, 20 ns). The second is ceil(t_cycle) - S - W, with t_cycle 600, 383, 240, 180, 120, 100, 80 ns.
- R6: In modes 0 to 4 the strobe stays low while IORDY, after a two-stage synchronizer, is low. It rises on the first edge where the minimum width has elapsed and the synchronized IORDY is high.
- R7: In modes 5 and 6 IORDY has no effect, and the strobe width is that of R3 or R4.
- R8: If IORDY is still low 125 cycles (1250 ns) after the minimum width has elapsed, the strobe rises anyway. The strobe is then low for W+125 cycles, and `timeout` is high together with `done`.
- R9: For a read, only `ata_rd_n` pulses, and `rdata` holds the `bus_din` value present at the edge where the strobe rises.
- R10: For a write, only `ata_wr_n` pulses, and `bus_oe` is high with `bus_dout` equal to the write data from acceptance until `done`. For a read, `bus_oe` stays 0.
- R11: `done` lasts one cycle, and a request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | PIO mode 0..6, latched with the request |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit register access |
| req_addr | input | 3 | Register address |
| req_cs | input | 2 | Chip selects, active high |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | IORDY stretch cut short, valid with done |
| rdata | output | 16 | Captured read data |
| iordy | input | 1 | Device ready, asynchronous |
| bus_din | input | 16 | Data bus input |
| bus_dout | output | 16 | Data bus output |
| bus_oe | output | 1 | Data bus driver enable |
| ata_addr | output | 3 | Bus address |
| ata_cs_n | output | 2 | Bus chip selects, active low |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |

## Verification
A phase counter or mode table that is off by one moves the strobe edge or the `done` pulse by a cycle. Every cycle of every access is compared, so such an error is seen in the very cycle it appears. A wrong IORDY path shows up the same way: an early or late strobe rise in stretched accesses, or a width change in modes 5 and 6 where IORDY must have no effect. A wrong capture edge gives wrong `rdata` because the bench changes `bus_din` on both sides of the rising strobe.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  localparam int NUM_TAB    = 8;   // modes 0..6, entry 7 mirrors mode 6
  localparam int RDY_MAX_NS = 1250;

  function automatic int ceil_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ns_cycle(input int m);
    case (m)
      0: return 600; 1: return 383; 2: return 240; 3: return 180;
      4: return 120; 5: return 100; default: return 80;
    endcase
  endfunction

  function automatic int ns_setup(input int m);
    case (m)
      0: return 70; 1: return 50; 2: return 30; 3: return 30;
      4: return 25; 5: return 15; default: return 10;
    endcase
  endfunction

  function automatic int ns_width16(input int m);
    case (m)
      0: return 165; 1: return 125; 2: return 100; 3: return 80;
      4: return 70; 5: return 65; default: return 55;
    endcase
  endfunction

  function automatic int ns_width8(input int m);
    return (m <= 2) ? 290 : ns_width16(m);
  endfunction

  function automatic int ns_recover(input int m);
    case (m)
      3: return 70; 4: return 25; 5: return 25; 6: return 20;
      7: return 20; default: return 0;
    endcase
  endfunction

  function automatic int ns_data_hold(input int m);
    case (m)
      0: return 30; 1: return 20; 2: return 15; 3: return 10;
      4: return 10; default: return 5;
    endcase
  endfunction

  function automatic int ns_addr_hold(input int m);
    case (m)
      0: return 20; 1: return 15; default: return 10;
    endcase
  endfunction

  function automatic bit rdy_used(input int m);
    return (m <= 4);
  endfunction

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[i] <= 1'b0;
        else        sh_q[i] <= sh_q[i-1];
      end
    end
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int CW     = 9
) (
  input  logic [2:0]    mode,
  input  logic          wide,
  output logic [CW-1:0] setup_cyc,
  output logic [CW-1:0] width_cyc,
  output logic [CW-1:0] recov_cyc,
  output logic          rdy_en
);
  logic [CW-1:0]      set_t   [NUM_TAB];
  logic [CW-1:0]      wid_w_t [NUM_TAB];
  logic [CW-1:0]      wid_n_t [NUM_TAB];
  logic [CW-1:0]      rec_w_t [NUM_TAB];
  logic [CW-1:0]      rec_n_t [NUM_TAB];
  logic [NUM_TAB-1:0] rdy_t;

  for (genvar m = 0; m < NUM_TAB; m++) begin : g_mode
    localparam int S  = ceil_cyc(ns_setup(m), CLK_NS);
    localparam int WW = ceil_cyc(ns_width16(m), CLK_NS);
    localparam int WN = ceil_cyc(ns_width8(m), CLK_NS);
    localparam int T0 = ceil_cyc(ns_cycle(m), CLK_NS);
    localparam int HM = max_int(max_int(ceil_cyc(ns_addr_hold(m), CLK_NS),
                                        ceil_cyc(ns_data_hold(m), CLK_NS)),
                                ceil_cyc(ns_recover(m), CLK_NS));
    assign set_t[m]   = CW'(S);
    assign wid_w_t[m] = CW'(WW);
    assign wid_n_t[m] = CW'(WN);
    assign rec_w_t[m] = CW'(max_int(HM, T0 - S - WW));
    assign rec_n_t[m] = CW'(max_int(HM, T0 - S - WN));
    assign rdy_t[m]   = rdy_used(m);
  end

  always_comb begin
    setup_cyc = set_t[mode];
    width_cyc = wide ? wid_w_t[mode] : wid_n_t[mode];
    recov_cyc = wide ? rec_w_t[mode] : rec_n_t[mode];
    rdy_en    = rdy_t[mode];
  end
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_pio_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int CW     = 9,
  parameter int DW     = 16,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_cs,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [DW-1:0] rdata,
  input  logic          iordy,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic [AW-1:0] ata_addr,
  output logic [1:0]    ata_cs_n,
  output logic          ata_rd_n,
  output logic          ata_wr_n
);
  localparam int TMO_CYC = ceil_cyc(RDY_MAX_NS, CLK_NS);

  logic          rst_s_n;
  logic          rdy_s;
  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    mode_q;
  logic          wr_q, wide_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    cs_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          done_q, done_d, tmo_q, tmo_d, pend_q, pend_d;
  logic          load, cap;
  logic [CW-1:0] setup_cyc, width_cyc, recov_cyc;
  logic          rdy_en, min_met;
  logic [CW-1:0] tmo_lim;

  ata_pio_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n)
  );

  ata_pio_sync #(.STAGES(2)) u_rdy_sync (
    .clk(clk), .rst_n(rst_s_n), .d(iordy), .q(rdy_s)
  );

  ata_pio_timing #(.CLK_NS(CLK_NS), .CW(CW)) u_timing (
    .mode(mode_q), .wide(wide_q),
    .setup_cyc(setup_cyc), .width_cyc(width_cyc),
    .recov_cyc(recov_cyc), .rdy_en(rdy_en)
  );

  assign min_met = (cnt_q >= width_cyc - 1'b1);
  assign tmo_lim = width_cyc + CW'(TMO_CYC - 1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    load    = 1'b0;
    cap     = 1'b0;
    done_d  = 1'b0;
    tmo_d   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          load    = 1'b1;
          phase_d = PH_SETUP;
          cnt_d   = '0;
          pend_d  = 1'b0;
        end
      end
      PH_SETUP: begin
        if (cnt_q == setup_cyc - 1'b1) begin
          phase_d = PH_STROBE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_STROBE: begin
        if (min_met && (!rdy_en || rdy_s)) begin
          phase_d = PH_RECOV;
          cnt_d   = '0;
          cap     = 1'b1;
        end else if (min_met && (cnt_q == tmo_lim)) begin
          phase_d = PH_RECOV;
          cnt_d   = '0;
          cap     = 1'b1;
          pend_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (cnt_q == recov_cyc - 1'b1) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
          tmo_d   = pend_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q  <= '0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      cs_q    <= '0;
      wdata_q <= '0;
    end else if (load) begin
      mode_q  <= mode;
      wr_q    <= req_write;
      wide_q  <= req_wide;
      addr_q  <= req_addr;
      cs_q    <= req_cs;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)  rdata_q <= '0;
    else if (cap)  rdata_q <= bus_din;
  end

  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;
  assign timeout  = tmo_q;
  assign rdata    = rdata_q;
  assign bus_dout = wdata_q;
  assign bus_oe   = busy && wr_q;
  assign ata_addr = addr_q;
  assign ata_cs_n = busy ? ~cs_q : 2'b11;
  assign ata_rd_n = !((phase_q == PH_STROBE) && !wr_q);
  assign ata_wr_n = !((phase_q == PH_STROBE) && wr_q);
endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk #(
  parameter int CLK_NS = 10,
  parameter int AW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic          bus_oe,
  input logic [AW-1:0] ata_addr,
  input logic [1:0]    ata_cs_n,
  input logic          ata_rd_n,
  input logic          ata_wr_n
);
  localparam int MIN_STROBE = (55 + CLK_NS - 1) / CLK_NS;

  logic        strb;
  logic [15:0] len_q;

  assign strb = !ata_rd_n || !ata_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (strb) len_q <= (len_q == 16'hffff) ? len_q : len_q + 16'd1;
    else           len_q <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ata_rd_n && ata_wr_n && !bus_oe && ata_cs_n == 2'b11));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ata_addr) && $stable(ata_cs_n)));

  p_strobe_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb && $past(strb)) |-> (len_q >= 16'(MIN_STROBE)));

  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_tmo_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (ata_rd_n || ata_wr_n));

  p_no_drive_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_rd_n |-> !bus_oe);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ata_pio_timer ata_pio_timer_chk #(.CLK_NS(CLK_NS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timeout(timeout),
  .bus_oe(bus_oe), .ata_addr(ata_addr), .ata_cs_n(ata_cs_n),
  .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n)
);

// File: tb/sim_ata_pio_timer.sv
module sim_ata_pio_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic        req_valid, req_write, req_wide;
  logic [2:0]  req_addr;
  logic [1:0]  req_cs;
  logic [15:0] req_wdata;
  logic        busy, done, timeout;
  logic [15:0] rdata;
  logic        iordy;
  logic [15:0] bus_din, bus_dout;
  logic        bus_oe;
  logic [2:0]  ata_addr;
  logic [1:0]  ata_cs_n;
  logic        ata_rd_n, ata_wr_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  ata_pio_timer u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_cs(req_cs), .req_wdata(req_wdata), .busy(busy), .done(done),
    .timeout(timeout), .rdata(rdata), .iordy(iordy), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .ata_addr(ata_addr),
    .ata_cs_n(ata_cs_n), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n)
  );

  // nanosecond minimums per mode, from the requirements
  int t0_ns [7] = '{600, 383, 240, 180, 120, 100, 80};
  int t1_ns [7] = '{70, 50, 30, 30, 25, 15, 10};
  int tw_ns [7] = '{165, 125, 100, 80, 70, 65, 55};
  int tn_ns [7] = '{290, 290, 290, 80, 70, 65, 55};
  int tr_ns [7] = '{0, 0, 0, 70, 25, 25, 20};
  int th_ns [7] = '{30, 20, 15, 10, 10, 5, 5};
  int ta_ns [7] = '{20, 15, 10, 10, 10, 10, 10};
  localparam int TMO = 125;

  function automatic int cdiv(input int ns);
    return (ns + 9) / 10;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // rise_c: 0 = IORDY high throughout, <0 = never rises, else cycle index of rise
  task automatic run(input string tag, input int m, input bit wr, input bit wide,
                     input logic [2:0] a, input logic [1:0] cs, input logic [15:0] wd,
                     input int rise_c, input logic [15:0] bus);
    int s, w, hmin, h, l, total;
    bit to;
    s    = cdiv(t1_ns[m]);
    w    = wide ? cdiv(tw_ns[m]) : cdiv(tn_ns[m]);
    hmin = imax(imax(cdiv(ta_ns[m]), cdiv(th_ns[m])), cdiv(tr_ns[m]));
    h    = imax(hmin, cdiv(t0_ns[m]) - s - w);
    to   = 1'b0;
    if (m >= 5 || rise_c == 0) l = w;
    else if (rise_c < 0) begin l = w + TMO; to = 1'b1; end
    else begin
      l = imax(w, rise_c + 2 - s);
      if (l > w + TMO) begin l = w + TMO; to = 1'b1; end
    end
    total = s + l + h;

    if (rise_c != 0) begin
      iordy = 1'b0;
      repeat (3) @(negedge clk);
    end
    mode = 3'(m); req_write = wr; req_wide = wide; req_addr = a; req_cs = cs;
    req_wdata = wd; req_valid = 1'b1; bus_din = ~bus;
    @(negedge clk);
    for (int j = 1; j <= total + 1; j++) begin
      logic strb, e_busy, e_done;
      logic [7:0] e_vec, a_vec;
      if (j == 1) begin req_addr = ~a; req_cs = ~cs; req_wdata = ~wd; end
      if (j == 3) req_valid = 1'b0;
      if (j == rise_c) iordy = 1'b1;
      if (j == s + l) bus_din = bus;
      if (j == s + l + 1) bus_din = ~bus;
      e_busy = (j <= total);
      strb   = (j > s) && (j <= s + l);
      e_done = (j == total + 1);
      e_vec  = {e_busy, !(strb && !wr), !(strb && wr), e_done, e_done && to,
                wr && e_busy, e_busy ? ~cs : 2'b11};
      a_vec  = {busy, ata_rd_n, ata_wr_n, done, timeout, bus_oe, ata_cs_n};
      check(tag, 32'(a_vec), 32'(e_vec));
      if (e_busy) check({tag, " R2 addr"}, 32'(ata_addr), 32'(a));
      if (wr && e_busy) check("R10 dout", 32'(bus_dout), 32'(wd));
      if (e_done && !wr) check("R9 rdata", 32'(rdata), 32'(bus));
      @(negedge clk);
    end
    iordy = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = '0; req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b1;
    req_addr = '0; req_cs = '0; req_wdata = '0; iordy = 1'b1; bus_din = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", 32'({busy, done, timeout, bus_oe, ata_rd_n, ata_wr_n, ata_cs_n}),
          32'(8'b0000_1111));

    for (int m = 0; m < 7; m++)
      run("R2 R3 R5 R9 R11", m, 1'b0, 1'b1, 3'(m), 2'b01, 16'h0, 0, 16'h1234 + 16'(m));
    for (int m = 0; m < 7; m++)
      run("R3 R5 R10", m, 1'b1, 1'b1, 3'(7 - m), 2'b10, 16'hA5C0 + 16'(m), 0, 16'h0);
    for (int m = 0; m < 7; m++)
      run("R4 R5", m, m[0], 1'b0, 3'd7, 2'b01, 16'h00F0, 0, 16'h00AB);

    run("R6", 2, 1'b0, 1'b1, 3'd5, 2'b01, 16'h0, 20, 16'hBEEF);
    run("R6", 4, 1'b1, 1'b1, 3'd2, 2'b10, 16'h5A5A, 3, 16'h0);
    run("R6", 0, 1'b0, 1'b0, 3'd1, 2'b01, 16'h0, 40, 16'hC0DE);
    run("R7", 5, 1'b0, 1'b1, 3'd3, 2'b01, 16'h0, -1, 16'h7777);
    run("R7", 6, 1'b1, 1'b0, 3'd4, 2'b10, 16'h1111, -1, 16'h0);
    run("R8", 0, 1'b0, 1'b1, 3'd6, 2'b01, 16'h0, -1, 16'hFACE);
    run("R8", 3, 1'b1, 1'b0, 3'd0, 2'b11, 16'h2222, -1, 16'h0);
    run("R8 R6", 4, 1'b0, 1'b1, 3'd1, 2'b01, 16'h0, 200, 16'h4321);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule